// File: doc/BRIEF.md
# Integer ALU with condition flags

This block is the arithmetic and logic stage of a simple 32-bit integer datapath. It takes two operands, an operation code, a set-flags control and the old value of the destination register. In the same cycle it returns a result, a write-enable for the destination and the candidate next value of the four condition flags (negative, zero, carry, overflow). The four flags live in a register inside the block. That register loads the candidate value on each clock edge where an operation executes.

The operations are:

- Arithmetic: add, subtract and reverse subtract. The carry-chained forms of add and subtract take the stored carry, so a 64-bit sum or difference can be built from two 32-bit steps.
- Bitwise: AND, OR, XOR, AND-NOT and OR-NOT.
- Move: move, move-complement, and a move that writes only the upper halfword.
- Compare and test: four forms that update flags and never write a destination.

Operand decode, the shifter and the register file sit outside the block.

Top module: `alu_core`

## Requirements
- R1: `opcode_i` encoding is ADD=0, ADC=1, SUB=2, SBC=3, RSB=4, AND=5, ORR=6, EOR=7, BIC=8, ORN=9, MOV=10, MVN=11, MOVT=12, CMP=13, CMN=14, TST=15, TEQ=16. `wr_en_o` is 1 for opcodes 0 to 12 and 0 for opcodes 13 to 16. Codes 17 to 31 give `wr_en_o`=0 and leave the flags unchanged.
- R2: The arithmetic results are:
  - ADD gives a+b.
  - SUB gives a-b.
  - RSB gives b-a.
  - CMP evaluates a-b.
  - CMN evaluates a+b.
- R3: ADC gives a+b+C and SBC gives a+~b+C, where C is the stored carry flag (`flags_o[1]`).
- R4: For arithmetic operations:
  - C is the carry out of the 32-bit adder. For subtraction this means C=1 when no borrow occurs.
  - V is set when both adder inputs have the same sign (after inversion for subtraction) and the sum has the other sign.
- R5: The bitwise results are:
  - AND gives a&b.
  - ORR gives a|b.
  - EOR gives a^b.
  - BIC gives a&~b.
  - ORN gives a|~b.
- R6: MOV gives b and MVN gives ~b.
- R7: MOVT gives {b[15:0], old_dst[15:0]}, that is, the immediate goes into bits 31:16 and the old low half is kept.
- R8: Flag update for opcodes 0 to 11 happens only when `set_flags_i` is 1; otherwise `flags_nxt_o` equals `flags_o`. N is bit 31 of the result and Z is set when the result is zero. Flags are packed {N,Z,C,V} in bits 3..0.
- R9: Bitwise and move operations (including TST and TEQ) update N and Z only; C and V keep their stored values.
- R10: CMP and CMN update all four flags, and TST (a&b) and TEQ (a^b) update N and Z, regardless of `set_flags_i`.
- R11: MOVT never changes the flags.
- R12: `flags_o` resets to 0. On a rising clock edge it loads `flags_nxt_o` when `exec_i` is 1 and holds its value when `exec_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Operation executes this cycle; the flags register loads on the edge |
| opcode_i | input | 5 | Operation code |
| set_flags_i | input | 1 | Flag update enable for opcodes 0 to 11 |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand; bits 15:0 are the MOVT immediate |
| old_dst_i | input | 32 | Current destination value, used by MOVT |
| result_o | output | 32 | Computed value |
| wr_en_o | output | 1 | Destination write enable |
| flags_nxt_o | output | 4 | Candidate next flags {N,Z,C,V} |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The bench builds the block with the default WIDTH of 32, so that the sign bit, the carry out and the halfword split of MOVT fall at the positions the requirements name. With this width, all-ones and 0x7FFFFFFF operands reach carry out, wraparound to zero and signed overflow. A two-step ADDS/ADC chain and a SUBS/SBC chain reach the stored-carry path.

Further vectors cover the remaining cases:
- Executions that leave the flags alone: `exec_i` low, `set_flags_i` low, and MOVT.
- Compare and test with `set_flags_i` low.
- A reserved opcode.
- A pseudo-random sweep of all opcodes.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_RSB  = 5'd4,  OP_AND = 5'd5,  OP_ORR = 5'd6,  OP_EOR = 5'd7,
    OP_BIC  = 5'd8,  OP_ORN = 5'd9,  OP_MOV = 5'd10, OP_MVN = 5'd11,
    OP_MOVT = 5'd12, OP_CMP = 5'd13, OP_CMN = 5'd14, OP_TST = 5'd15,
    OP_TEQ  = 5'd16
  } alu_op_e;

  localparam int unsigned FLAG_N = 3;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_C = 1;
  localparam int unsigned FLAG_V = 0;

  function automatic logic op_is_arith(logic [4:0] op);
    return (op <= 5'd4) || (op == 5'd13) || (op == 5'd14);
  endfunction

  function automatic logic op_is_cmp(logic [4:0] op);
    return (op >= 5'd13) && (op <= 5'd16);
  endfunction

  function automatic logic op_is_valid(logic [4:0] op);
    return op <= 5'd16;
  endfunction
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  logic [WIDTH:0] full;

  always_comb begin
    full   = {1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i};
    sum_o  = full[WIDTH-1:0];
    cout_o = full[WIDTH];
    ovf_o  = (x_i[WIDTH-1] == y_i[WIDTH-1]) && (full[WIDTH-1] != x_i[WIDTH-1]);
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned HALF = WIDTH / 2
) (
  input  logic [4:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] old_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_ORR:         res_o = a_i | b_i;
      OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
      OP_BIC:         res_o = a_i & ~b_i;
      OP_ORN:         res_o = a_i | ~b_i;
      OP_MOV:         res_o = b_i;
      OP_MVN:         res_o = ~b_i;
      OP_MOVT:        res_o = {b_i[HALF-1:0], old_i[HALF-1:0]};
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_flag_ctrl.sv
module alu_flag_ctrl
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [4:0]       op_i,
  input  logic             set_flags_i,
  input  logic [WIDTH-1:0] value_i,
  input  logic             cout_i,
  input  logic             ovf_i,
  input  logic [3:0]       flags_q_i,
  output logic [3:0]       flags_nxt_o,
  output logic             wr_en_o
);
  logic upd, arith;

  always_comb begin
    arith   = op_is_arith(op_i);
    wr_en_o = op_is_valid(op_i) && !op_is_cmp(op_i);
    upd     = op_is_cmp(op_i) ||
              (set_flags_i && op_is_valid(op_i) && (op_i != OP_MOVT));
    flags_nxt_o = flags_q_i;
    if (upd) begin
      flags_nxt_o[FLAG_N] = value_i[WIDTH-1];
      flags_nxt_o[FLAG_Z] = (value_i == '0);
      if (arith) begin
        flags_nxt_o[FLAG_C] = cout_i;
        flags_nxt_o[FLAG_V] = ovf_i;
      end
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exec_i,
  input  logic [4:0]       opcode_i,
  input  logic             set_flags_i,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic [WIDTH-1:0] old_dst_i,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_en_o,
  output logic [3:0]       flags_nxt_o,
  output logic [3:0]       flags_o
);
  logic [3:0]       flags_q;
  logic [WIDTH-1:0] add_x, add_y, add_sum, logic_res;
  logic             add_cin, add_cout, add_ovf;

  // adder operand steering; subtract forms use x + ~y + cin
  always_comb begin
    add_x   = op_a_i;
    add_y   = op_b_i;
    add_cin = 1'b0;
    unique case (opcode_i)
      OP_ADC:         add_cin = flags_q[FLAG_C];
      OP_SUB, OP_CMP: begin add_y = ~op_b_i; add_cin = 1'b1; end
      OP_SBC:         begin add_y = ~op_b_i; add_cin = flags_q[FLAG_C]; end
      OP_RSB:         begin add_x = op_b_i; add_y = ~op_a_i; add_cin = 1'b1; end
      default: ;
    endcase
  end

  alu_adder #(.WIDTH(WIDTH)) u_adder (
    .x_i(add_x), .y_i(add_y), .cin_i(add_cin),
    .sum_o(add_sum), .cout_o(add_cout), .ovf_o(add_ovf)
  );

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .op_i(opcode_i), .a_i(op_a_i), .b_i(op_b_i), .old_i(old_dst_i),
    .res_o(logic_res)
  );

  assign result_o = op_is_arith(opcode_i) ? add_sum : logic_res;

  alu_flag_ctrl #(.WIDTH(WIDTH)) u_flags (
    .op_i(opcode_i), .set_flags_i(set_flags_i), .value_i(result_o),
    .cout_i(add_cout), .ovf_i(add_ovf), .flags_q_i(flags_q),
    .flags_nxt_o(flags_nxt_o), .wr_en_o(wr_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flags_q <= '0;
    else if (exec_i) flags_q <= flags_nxt_o;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned HALF = WIDTH / 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             exec_i,
  input logic [4:0]       opcode_i,
  input logic             set_flags_i,
  input logic [WIDTH-1:0] op_a_i,
  input logic [WIDTH-1:0] op_b_i,
  input logic [WIDTH-1:0] old_dst_i,
  input logic [WIDTH-1:0] result_o,
  input logic             wr_en_o,
  input logic [3:0]       flags_nxt_o,
  input logic [3:0]       flags_o
);
  // R1
  cmp_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i >= 5'd13) |-> !wr_en_o);
  // R1
  reserved_noop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i > 5'd16) |-> (flags_nxt_o == flags_o));
  // R7
  movt_low_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == 5'd12) |-> (result_o[HALF-1:0] == old_dst_i[HALF-1:0]));
  // R8
  no_set_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i < 5'd12 && !set_flags_i) |-> (flags_nxt_o == flags_o));
  // R8
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i < 5'd12 && set_flags_i) |-> (flags_nxt_o[2] == (result_o == '0)));
  // R9
  logic_cv_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i >= 5'd5 && opcode_i <= 5'd12) |-> (flags_nxt_o[1:0] == flags_o[1:0]));
  // R11
  movt_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == 5'd12) |-> (flags_nxt_o == flags_o));
  // R12
  flag_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |=> (flags_o == $past(flags_nxt_o)));
  // R12
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable(flags_o));
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_alu_core_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .exec_i(exec_i), .opcode_i(opcode_i),
  .set_flags_i(set_flags_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
  .old_dst_i(old_dst_i), .result_o(result_o), .wr_en_o(wr_en_o),
  .flags_nxt_o(flags_nxt_o), .flags_o(flags_o)
);

// File: tb/alu_core_bench.sv
`timescale 1ns/100ps
module alu_core_bench;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          exec = 1'b0;
  logic [4:0]    opcode = '0;
  logic          set_flags = 1'b0;
  logic [W-1:0]  op_a = '0, op_b = '0, old_dst = '0;
  logic [W-1:0]  result;
  logic          wr_en;
  logic [3:0]    flags_nxt, flags;

  always #2.5 clk = ~clk;

  alu_core #(.WIDTH(W)) u_alu_core (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .opcode_i(opcode),
    .set_flags_i(set_flags), .op_a_i(op_a), .op_b_i(op_b), .old_dst_i(old_dst),
    .result_o(result), .wr_en_o(wr_en), .flags_nxt_o(flags_nxt), .flags_o(flags)
  );

  typedef struct {
    logic [W-1:0] res;
    logic         wr;
    logic [3:0]   nxt;
    logic [3:0]   cur;
    logic         chk_res;
    string        tag;
  } exp_t;

  exp_t        q[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [3:0]  mdl_flags = '0;
  logic [31:0] lfsr = 32'h1234_5678;

  function automatic exp_t model(logic [4:0] op, logic [W-1:0] a, logic [W-1:0] b,
                                 logic [W-1:0] old, logic sf, logic [3:0] fl);
    exp_t e;
    logic [W:0] s;
    logic [W-1:0] x, y;
    logic cin, arith, upd, cmp;
    x = a; y = b; cin = 1'b0; arith = 1'b1;
    e.tag = "R2";
    case (op)
      5'd0, 5'd14: ;
      5'd1:        begin cin = fl[1]; e.tag = "R3"; end
      5'd2, 5'd13: begin y = ~b; cin = 1'b1; end
      5'd3:        begin y = ~b; cin = fl[1]; e.tag = "R3"; end
      5'd4:        begin x = b; y = ~a; cin = 1'b1; end
      default:     arith = 1'b0;
    endcase
    s = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    e.res = s[W-1:0];
    if (!arith) begin
      case (op)
        5'd5, 5'd15: begin e.res = a & b;  e.tag = "R5"; end
        5'd6:        begin e.res = a | b;  e.tag = "R5"; end
        5'd7, 5'd16: begin e.res = a ^ b;  e.tag = "R5"; end
        5'd8:        begin e.res = a & ~b; e.tag = "R5"; end
        5'd9:        begin e.res = a | ~b; e.tag = "R5"; end
        5'd10:       begin e.res = b;      e.tag = "R6"; end
        5'd11:       begin e.res = ~b;     e.tag = "R6"; end
        5'd12:       begin e.res = {b[15:0], old[15:0]}; e.tag = "R7"; end
        default:     begin e.res = '0;     e.tag = "R1"; end
      endcase
    end
    cmp  = (op >= 5'd13 && op <= 5'd16);
    e.wr = (op <= 5'd12);
    upd  = cmp || (sf && op <= 5'd11);
    e.nxt = fl;
    if (upd) begin
      e.nxt[3] = e.res[W-1];
      e.nxt[2] = (e.res == '0);
      if (arith) begin
        e.nxt[1] = s[W];
        e.nxt[0] = (x[W-1] == y[W-1]) && (e.res[W-1] != x[W-1]);
      end
    end
    e.cur = fl;
    e.chk_res = !cmp && op <= 5'd16;
    return e;
  endfunction

  task automatic drive(input logic [4:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] old, input logic sf, input logic ex, input string tag);
    exp_t e;
    @(negedge clk);
    opcode = op; op_a = a; op_b = b; old_dst = old; set_flags = sf; exec = ex;
    e = model(op, a, b, old, sf, mdl_flags);
    if (tag != "") e.tag = tag;
    q.push_back(e);
    if (ex) mdl_flags = e.nxt;
  endtask

  task automatic cmp(input string tag, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (op %0d)", tag, what, act, exp, opcode);
    end
  endtask

  // monitor: sample combinational outputs mid-cycle, before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        if (e.chk_res) cmp(e.tag, "result", result, e.res);
        cmp("R1", "wr_en", {31'b0, wr_en}, {31'b0, e.wr});
        cmp(e.tag, "flags_nxt", {28'b0, flags_nxt}, {28'b0, e.nxt});
        cmp("R12", "flags", {28'b0, flags}, {28'b0, e.cur});
      end
    end
  end

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    cmp("R12", "reset flags", {28'b0, flags}, 32'h0);
    rst_n = 1'b1;
    // R4 carry out and zero result
    drive(5'd0, 32'hFFFF_FFFF, 32'h1, 0, 1, 1, "R4");
    // R4 signed overflow
    drive(5'd0, 32'h7FFF_FFFF, 32'h1, 0, 1, 1, "R4");
    // R3 64-bit add: low word carries, high word takes it
    drive(5'd0, 32'h8000_0000, 32'h8000_0000, 0, 1, 1, "R3");
    drive(5'd1, 32'h0000_0001, 32'h0000_0002, 0, 1, 1, "R3");
    // R4 subtract: equal gives Z and C, smaller gives borrow
    drive(5'd2, 32'd5, 32'd5, 0, 1, 1, "R4");
    drive(5'd2, 32'd3, 32'd5, 0, 1, 1, "R4");
    // R3 subtract with stored borrow
    drive(5'd3, 32'd10, 32'd4, 0, 1, 1, "R3");
    // R2 reverse subtract
    drive(5'd4, 32'd4, 32'd1280, 0, 1, 1, "R2");
    // R8 no set-flags leaves flags
    drive(5'd0, 32'hFFFF_FFFF, 32'h1, 0, 0, 1, "R8");
    // R10 compare/test update flags without set_flags
    drive(5'd13, 32'd7, 32'd7, 0, 0, 1, "R10");
    drive(5'd14, 32'h8000_0000, 32'h8000_0000, 0, 0, 1, "R10");
    drive(5'd15, 32'hF0, 32'h0F, 0, 0, 1, "R10");
    drive(5'd16, 32'h8000_0000, 32'h1, 0, 0, 1, "R10");
    // R9 logic with set flags keeps C and V
    drive(5'd0, 32'h7FFF_FFFF, 32'h8000_0001, 0, 1, 1, "R9");
    drive(5'd8, 32'hFFFF_00AB, 32'h0000_00AB, 0, 1, 1, "R9");
    drive(5'd9, 32'h0, 32'hFFFF_FFFF, 0, 1, 1, "R9");
    drive(5'd11, 32'h0, 32'h0, 0, 1, 1, "R6");
    drive(5'd10, 32'h0, 32'h1234_5678, 0, 1, 1, "R6");
    // R7 / R11 top halfword move
    drive(5'd12, 32'h0, 32'h0000_F0F0, 32'hAAAA_3400, 1, 1, "R11");
    // R12 exec low holds flags
    drive(5'd13, 32'd0, 32'd1, 0, 0, 0, "R12");
    drive(5'd13, 32'd1, 32'd1, 0, 0, 1, "R12");
    // R1 reserved code
    drive(5'd20, 32'd1, 32'd1, 0, 1, 1, "R1");
    drive(5'd31, 32'd0, 32'd0, 0, 1, 1, "R1");
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra, rb, ro;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      ra = lfsr;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      rb = (i % 7 == 0) ? ra : lfsr;
      ro = lfsr ^ 32'h5A5A_A5A5;
      drive(5'(i % 17), ra, rb, ro, lfsr[3], lfsr[9] | lfsr[4], "");
    end
    @(negedge clk);
    @(negedge clk);
    #2;
    report();
  end
endmodule